// File: doc/BRIEF.md
# PCI Type-0 Configuration Register File

This block holds the 256-byte configuration space of one PCI function. It reaches the host only through configuration cycles. The bus engine in front of it supplies a dword index, byte enables, write data and a strobe. The block returns the addressed dword combinationally. The space has a standard 64-byte type-0 header and one power-management capability. That capability is linked from the header and occupies the two dwords at 40h and 44h.

From its registers the block drives the enables for I/O, memory and bus mastering, and the current power state. It also compares a bus address against the three base-address registers (I/O, memory and expansion ROM) and raises a hit for each match. Status error bits are set by event inputs from the rest of the device, and software clears them by writing ones. Any location that is not implemented reads zero and ignores writes. Every multi-byte field is little-endian: byte lane i carries bits 8i+7..8i.

Top module: `pci_cfg_space`

## Requirements
- R1: After reset, identification fields read their parameter values, and the class code occupies bits 31:8 of dword 2. Writable fields read zero, status (bits 31:16 of dword 1) reads 0010h, and dword 13 (34h) reads 00000040h.
- R2: cfg_rdata shows the dword selected by cfg_dw in the same cycle. A write takes effect at the clock edge where cfg_req and cfg_we are both 1.
- R3: cfg_be[i] gates write byte lane i, which is bits 8i+7..8i. A lane that is not enabled keeps its value.
- R4: Dwords 3, 6 to 10, 14 and 18 to 63 read zero, and writes to them have no effect. Read-only fields ignore writes.
- R5: Only command bits 0, 1, 2, 6, 8 and 10 (dword 1, bits 15:0) are writable, and the other command bits read 0. Bits 0, 1 and 2 drive cmd_io_en, cmd_mem_en and cmd_master_en.
- R6: err_set[0..5] set status bits 8, 11, 12, 13, 14 and 15 respectively. Writing 1 to such a bit clears it, and writing 0 leaves it unchanged. If an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: In the I/O base (dword 4), bits 31:IO_SZ are writable, bit 0 reads 1 and the other bits read 0. In the memory base (dword 5), bits 31:MEM_SZ are writable and the rest read 0. In the ROM base (dword 12), bits 31:ROM_SZ and enable bit 0 are writable.
- R8: Dword 16 (40h) reads {PMC, 8'h00, 8'h01}. In dword 17 (44h), bits 1:0 hold the writable power state, which drives pwr_state. All other bits of dword 17 read 0.
- R9: In dword 15 (3Ch), byte 0 is the writable interrupt line. Bytes 3..1 read MAX_LAT, MIN_GNT and INT_PIN.
- R10: io_hit is set when cmd_io_en is 1 and bus_addr[31:IO_SZ] equals the I/O base. mem_hit requires cmd_mem_en and a match on bits 31:MEM_SZ. rom_hit requires cmd_mem_en, ROM enable bit 0 and a match on bits 31:ROM_SZ.
- R11: cfg_we with cfg_req low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Configuration access strobe |
| cfg_we | input | 1 | Write when 1, read when 0 |
| cfg_dw | input | 6 | Dword index in the 256-byte space |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected dword |
| err_set | input | 6 | Status error events |
| bus_addr | input | 32 | Address compared against the base registers |
| io_hit | output | 1 | I/O base match |
| mem_hit | output | 1 | Memory base match |
| rom_hit | output | 1 | Expansion ROM match |
| cmd_io_en | output | 1 | I/O space enable |
| cmd_mem_en | output | 1 | Memory space enable |
| cmd_master_en | output | 1 | Bus master enable |
| pwr_state | output | 2 | Current power state |

## Verification
Setting a status error bit from the device side and clearing it from the host can fall in the same cycle. The bench provokes this by raising err_set for one bit during the very cycle that a write of all ones to status is committed. The bit must then read 1, while every other error bit set earlier reads 0. Separate cases check that each path works alone: an event with no write, a write of 1 with no event, and a write of 0.

// File: rtl/pci_cfg_space.sv
module pci_cfg_space #(
  parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID  = 16'h5A31,
  parameter logic [7:0]  REV_ID     = 8'h02,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter logic [15:0] SUBSYS_VID = 16'h1D0F,
  parameter logic [15:0] SUBSYS_ID  = 16'h0001,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [7:0]  MIN_GNT    = 8'h18,
  parameter logic [7:0]  MAX_LAT    = 8'h18,
  parameter logic [15:0] PMC        = 16'h0002,
  parameter int          IO_SZ      = 5,
  parameter int          MEM_SZ     = 12,
  parameter int          ROM_SZ     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_req,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_dw,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [5:0]  err_set,
  input  logic [31:0] bus_addr,
  output logic        io_hit,
  output logic        mem_hit,
  output logic        rom_hit,
  output logic        cmd_io_en,
  output logic        cmd_mem_en,
  output logic        cmd_master_en,
  output logic [1:0]  pwr_state
);
  localparam logic [15:0] CMD_M = 16'h0547;
  localparam logic [31:0] IO_M  = 32'hFFFF_FFFF << IO_SZ;
  localparam logic [31:0] MEM_M = 32'hFFFF_FFFF << MEM_SZ;
  localparam logic [31:0] ROM_M = (32'hFFFF_FFFF << ROM_SZ) | 32'h1;

  logic [15:0] cmd;
  logic [5:0]  stat_err;
  logic [31:0] io_bar, mem_bar, rom_bar;
  logic [7:0]  int_line;
  logic [1:0]  pstate;

  wire        wr = cfg_req & cfg_we;
  wire [31:0] bm = {{8{cfg_be[3]}}, {8{cfg_be[2]}}, {8{cfg_be[1]}}, {8{cfg_be[0]}}};
  wire [31:0] wv = cfg_wdata & bm;
  wire [5:0]  clr = (wr && cfg_dw == 6'd1) ? {wv[31:27], wv[24]} : 6'd0;
  wire [15:0] status = {stat_err[5:1], 2'b00, stat_err[0], 3'b000, 1'b1, 4'h0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd      <= '0;
      stat_err <= '0;
      io_bar   <= '0;
      mem_bar  <= '0;
      rom_bar  <= '0;
      int_line <= '0;
      pstate   <= '0;
    end else begin
      stat_err <= (stat_err & ~clr) | err_set;
      if (wr) begin
        case (cfg_dw)
          6'd1:  cmd     <= (cmd & ~(bm[15:0] & CMD_M)) | (wv[15:0] & CMD_M);
          6'd4:  io_bar  <= (io_bar & ~(bm & IO_M)) | (wv & IO_M);
          6'd5:  mem_bar <= (mem_bar & ~(bm & MEM_M)) | (wv & MEM_M);
          6'd12: rom_bar <= (rom_bar & ~(bm & ROM_M)) | (wv & ROM_M);
          6'd15: if (cfg_be[0]) int_line <= cfg_wdata[7:0];
          6'd17: if (cfg_be[0]) pstate <= cfg_wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_dw)
      6'd0:    cfg_rdata = {DEVICE_ID, VENDOR_ID};
      6'd1:    cfg_rdata = {status, cmd};
      6'd2:    cfg_rdata = {CLASS_CODE, REV_ID};
      6'd4:    cfg_rdata = io_bar | 32'h1;
      6'd5:    cfg_rdata = mem_bar;
      6'd11:   cfg_rdata = {SUBSYS_ID, SUBSYS_VID};
      6'd12:   cfg_rdata = rom_bar;
      6'd13:   cfg_rdata = 32'h0000_0040;
      6'd15:   cfg_rdata = {MAX_LAT, MIN_GNT, INT_PIN, int_line};
      6'd16:   cfg_rdata = {PMC, 8'h00, 8'h01};
      6'd17:   cfg_rdata = {30'd0, pstate};
      default: cfg_rdata = '0;
    endcase
  end

  assign cmd_io_en     = cmd[0];
  assign cmd_mem_en    = cmd[1];
  assign cmd_master_en = cmd[2];
  assign pwr_state     = pstate;
  assign io_hit  = cmd[0] && bus_addr[31:IO_SZ] == io_bar[31:IO_SZ];
  assign mem_hit = cmd[1] && bus_addr[31:MEM_SZ] == mem_bar[31:MEM_SZ];
  assign rom_hit = cmd[1] && rom_bar[0] && bus_addr[31:ROM_SZ] == rom_bar[31:ROM_SZ];
  wire unused_lsb = ^bus_addr[IO_SZ-1:0];
endmodule

module pci_cfg_space_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_req,
  input logic        cfg_we,
  input logic [5:0]  cfg_dw,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_rdata,
  input logic [5:0]  err_set,
  input logic        io_hit,
  input logic        mem_hit,
  input logic        rom_hit,
  input logic        cmd_io_en,
  input logic        cmd_mem_en,
  input logic        cmd_master_en,
  input logic [1:0]  pwr_state,
  input logic [5:0]  stat_err
);
  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((stat_err & $past(err_set)) == $past(err_set)));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cfg_req && cfg_we) && err_set == 6'd0) |=> $stable(stat_err));
  a_r5_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && cfg_we && cfg_dw == 6'd1 && cfg_be[0])
      |=> $stable({cmd_io_en, cmd_mem_en, cmd_master_en}));
  a_r8_pwr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_req && cfg_we && cfg_dw == 6'd17 && cfg_be[0]) |=> $stable(pwr_state));
  a_r10_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> cmd_io_en);
  a_r10_mem_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_hit || rom_hit) |-> cmd_mem_en);
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dw >= 6'd18) |-> cfg_rdata == 32'd0);
endmodule

bind pci_cfg_space pci_cfg_space_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
  .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata), .err_set(err_set),
  .io_hit(io_hit), .mem_hit(mem_hit), .rom_hit(rom_hit),
  .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en), .cmd_master_en(cmd_master_en),
  .pwr_state(pwr_state), .stat_err(stat_err)
);

// File: tb/sim_pci_cfg_space.sv
module sim_pci_cfg_space;
  localparam int IO_SZ = 5, MEM_SZ = 12, ROM_SZ = 16;
  logic clk = 0, rst_n = 0, cfg_req = 0, cfg_we = 0;
  logic [5:0] cfg_dw = 0, err_set = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata, bus_addr = 0;
  logic io_hit, mem_hit, rom_hit, cmd_io_en, cmd_mem_en, cmd_master_en;
  logic [1:0] pwr_state;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_cfg_space u0 (.*);

  logic [15:0] m_cmd = 0;
  logic [15:0] m_st = 16'h0010;
  logic [31:0] m_io = 0, m_mem = 0, m_rom = 0;
  logic [7:0]  m_il = 0;
  logic [1:0]  m_ps = 0;

  function automatic logic [31:0] mexp(int dw);
    case (dw)
      0: return 32'h5A31_1D0F;
      1: return {m_st, m_cmd};
      2: return 32'h0200_0002;
      4: return m_io | 32'h1;
      5: return m_mem;
      11: return 32'h0001_1D0F;
      12: return m_rom;
      13: return 32'h40;
      15: return {24'h18_18_01, m_il};
      16: return 32'h0002_0001;
      17: return {30'd0, m_ps};
      default: return 0;
    endcase
  endfunction

  task automatic mwrite(int dw, logic [3:0] be, logic [31:0] d);
    logic [31:0] b = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    logic [31:0] iom = 32'hFFFF_FFFF << IO_SZ;
    logic [31:0] mm = 32'hFFFF_FFFF << MEM_SZ;
    logic [31:0] rm = (32'hFFFF_FFFF << ROM_SZ) | 1;
    case (dw)
      1: begin
        m_cmd = (m_cmd & ~(b[15:0] & 16'h0547)) | (d[15:0] & b[15:0] & 16'h0547);
        m_st = m_st & ~(d[31:16] & b[31:16] & 16'hF900);
      end
      4: m_io = (m_io & ~(b & iom)) | (d & b & iom);
      5: m_mem = (m_mem & ~(b & mm)) | (d & b & mm);
      12: m_rom = (m_rom & ~(b & rm)) | (d & b & rm);
      15: if (be[0]) m_il = d[7:0];
      17: if (be[0]) m_ps = d[1:0];
      default: ;
    endcase
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int dw, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_dw = 6'(dw); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0;
    mwrite(dw, be, d);
  endtask

  task automatic rd(int dw, string tag);
    @(negedge clk);
    cfg_dw = 6'(dw);
    #1 chk($sformatf("%s dw%0d", tag, dw), cfg_rdata, mexp(dw));
  endtask

  function automatic logic [15:0] ebit(int k);
    int pos[6] = '{8, 11, 12, 13, 14, 15};
    return 16'(1) << pos[k];
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R4: reset values over the whole space
    for (int i = 0; i < 64; i++) rd(i, "R1/R4 reset");
    chk("R5 outputs at reset", {29'd0, cmd_master_en, cmd_mem_en, cmd_io_en}, 0);
    // R2 R4 R5 R7 R8 R9: all ones into each dword, full re-read
    for (int i = 0; i < 64; i++) begin
      wr(i, 4'hF, 32'hFFFF_FFFF);
      for (int j = 0; j < 64; j++) rd(j, "R2/R4/R7 ones");
    end
    chk("R5 cmd outputs", {29'd0, cmd_master_en, cmd_mem_en, cmd_io_en}, 32'd7);
    chk("R8 pwr_state", {30'd0, pwr_state}, 32'd3);
    // R3: byte enable sweep
    for (int be = 0; be < 16; be++) begin
      foreach (mexp_dws[k]) begin
        wr(mexp_dws[k], 4'(be), 32'h5A3C_96F0 ^ {4{8'(be * 17)}});
        rd(mexp_dws[k], "R3 byte lanes");
      end
    end
    // R11: write strobe without request
    @(negedge clk);
    cfg_req = 0; cfg_we = 1; cfg_dw = 6'd4; cfg_be = 4'hF; cfg_wdata = 32'h1234_5678;
    @(negedge clk); cfg_we = 0;
    rd(4, "R11 no req");
    // R6: each event alone, write 0, write 1
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); err_set = 6'(1 << k);
      @(negedge clk); err_set = 0;
      m_st |= ebit(k);
      rd(1, "R6 event sets");
      wr(1, 4'hC, 32'h0000_0000);
      rd(1, "R6 write 0 keeps");
      wr(1, 4'hC, {ebit(k), 16'h0});
      rd(1, "R6 write 1 clears");
    end
    // R6: event and clearing write in the same cycle
    @(negedge clk); err_set = 6'h3F;
    @(negedge clk); err_set = 0; m_st |= 16'hF900;
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_dw = 6'd1; cfg_be = 4'hC; cfg_wdata = 32'hFFFF_0000;
    err_set = 6'b000100;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0; err_set = 0;
    mwrite(1, 4'hC, 32'hFFFF_0000);
    m_st |= ebit(2);
    rd(1, "R6 set wins");
    // R10: hit compares
    wr(1, 4'h3, 32'h0000_0003);
    wr(4, 4'hF, 32'h1000_0020);
    wr(5, 4'hF, 32'h8000_3000);
    wr(12, 4'hF, 32'hC001_0001);
    @(negedge clk); bus_addr = 32'h1000_003C;
    #1 chk("R10 io hit", {31'd0, io_hit}, 1);
    bus_addr = 32'h1000_0040;
    #1 chk("R10 io miss", {31'd0, io_hit}, 0);
    bus_addr = 32'h8000_3FFC;
    #1 chk("R10 mem hit", {31'd0, mem_hit}, 1);
    bus_addr = 32'hC001_FFF0;
    #1 chk("R10 rom hit", {31'd0, rom_hit}, 1);
    wr(12, 4'h1, 32'h0);
    @(negedge clk);
    #1 chk("R10 rom disabled", {31'd0, rom_hit}, 0);
    wr(1, 4'h1, 32'h0);
    bus_addr = 32'h1000_0020;
    @(negedge clk);
    #1 chk("R10 io gated by cmd", {31'd0, io_hit}, 0);
    bus_addr = 32'h8000_3000;
    #1 chk("R10 mem gated by cmd", {31'd0, mem_hit}, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  int mexp_dws[6] = '{1, 4, 5, 12, 15, 17};
endmodule